// File: doc/BRIEF.md
# Interlaced Composite Sync Generator

This block builds a 2:1 interlaced monochrome mixed-sync waveform from a master clock that runs at 32 times the line rate. A position counter steps through the 32 clocks of each line. A line counter closes the frame after 525 lines or after 625 lines. Every output is a pure function of the two counters, so a downstream video pipeline can read the raster position (`lineNum`, `linePos`) and the field flag together with the sync levels on the same cycle.

Each field opens with a vertical interval of eighteen half-lines. The first six carry narrow equalizing pulses, the next six carry broad serrated vertical pulses, and the last six carry equalizing pulses again. The second field's interval begins half a line later than the first field's interval would, and this offset produces the interlace. The master clock retimes every output, so the horizontal phase does not slip across the vertical interval.

Two active-low inputs move the raster to a fixed point so it can be brought into line with an outside reference. One moves it to the first equalizing pulse and the other to the first broad pulse. The counters advance only on cycles where `clkEn` is high.

Top module: `sync_gen`

## Requirements
- R1: On every enabled clock with no reset request, `linePos` advances by one modulo 32. When it wraps from 31 to 0, `lineNum` advances by one.
- R2: A frame holds 525 lines (lineNum 0..524) when the latched mode is low and 625 lines (0..624) when it is high. After 524 or 624 the line count returns to 0.
- R3: A new `modeLong` value takes effect only when the frame wraps to line 0, position 0. The frame that is running when the mode changes keeps its original length.
- R4: Outside the vertical interval, `syncN` is low at positions 0 and 1 of a line and high at every other position. This includes the whole second half of the line.
- R5: Half-line index h = 2*lineNum + (linePos >= 16). Let f = h for h below the frame's line count, and f = h - linecount otherwise. For f in 0..5 and f in 12..17, `syncN` is low only on the first clock of the half-line.
- R6: For f in 6..11, `syncN` is low at half-line offsets 0..12 and high at offsets 13..15. The high part is the serration.
- R7: `fieldSecond` is high exactly when h is at or above the frame's line count. For 525 lines this starts at line 262, position 16, and for 625 lines at line 312, position 16.
- R8: `hDriveN` is low at positions 0 and 1 of every line, including the lines of the vertical interval, and high at all other positions.
- R9: When `eqResetN` is low on an enabled clock, the raster moves to line 0, position 0, the first equalizing pulse.
- R10: When `vsResetN` is low and `eqResetN` is high on an enabled clock, the raster moves to line 3, position 0, the first broad pulse.
- R11: When both reset inputs are low on an enabled clock, the equalizing target (line 0) wins.
- R12: While `clkEn` is low, no output changes. Reset requests made on those cycles are ignored.
- R13: After `rstN`, the outputs read line 0, position 0, `syncN` low, `hDriveN` low, `fieldSecond` low, and the mode is 525 lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 32 per line |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEn | input | 1 | Count enable |
| modeLong | input | 1 | 0 selects 525 lines, 1 selects 625 lines; applied at the next frame start |
| eqResetN | input | 1 | Active-low jump to the first equalizing pulse |
| vsResetN | input | 1 | Active-low jump to the first broad pulse |
| syncN | output | 1 | Mixed sync, active low, registered |
| hDriveN | output | 1 | Horizontal drive, active low, registered |
| lineNum | output | 10 | Current line of the frame |
| linePos | output | 5 | Clock position within the line |
| fieldSecond | output | 1 | High during the second field |

## Verification
A fault in the position or line counter shows on `linePos` or `lineNum` at the very next enabled clock. The bench keeps its own count of the raster position and compares it against these outputs on every cycle. A wrong half-line decode, such as a field threshold off by one or a broad window misplaced, changes `syncN` within the half-line where it happens, and the bench checks it against a level computed from the position. A mode latched at the wrong time only shows up at the end of the frame, as a wrap at line 524 where 624 was expected (or the reverse). The bench therefore runs through complete frames on each side of a mode change.

// File: rtl/sync_gen_pkg.sv
package sync_gen_pkg;
  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic step;      // counters may move this clock
    logic jumpEq;    // load first equalizing pulse
    logic jumpVs;    // load first broad pulse
    logic modeLong;  // frame length in force
  } syncCtl_t;
endpackage

// File: rtl/sync_gen_ctrl.sv
module sync_gen_ctrl
  import sync_gen_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     clkEn,
  input  logic     modeLong,
  input  logic     eqResetN,
  input  logic     vsResetN,
  input  logic     frameEnd,
  output syncCtl_t ctl
);
  logic modeCur;
  logic wrapNow;

  assign wrapNow = clkEn && eqResetN && vsResetN && frameEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        modeCur <= 1'b0;
    else if (wrapNow) modeCur <= modeLong;
  end

  always_comb begin
    ctl.step     = clkEn;
    ctl.jumpEq   = clkEn && !eqResetN;
    ctl.jumpVs   = clkEn && eqResetN && !vsResetN;
    ctl.modeLong = modeCur;
  end

  // R3: the frame length only switches at a frame wrap
  p_mode_at_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(modeCur) |-> $past(wrapNow));
endmodule

// File: rtl/sync_gen_datapath.sv
module sync_gen_datapath
  import sync_gen_pkg::*;
#(
  parameter int CLKS_PER_LINE = 32,
  parameter int LINES_SHORT   = 525,
  parameter int LINES_LONG    = 625,
  parameter int EQ_PULSES     = 6,
  parameter int BROAD_PULSES  = 6,
  parameter int HSYNC_CLKS    = 2,
  parameter int EQ_CLKS       = 1,
  parameter int BROAD_CLKS    = 13,
  parameter int HDRIVE_CLKS   = 2,
  localparam int HPOS_W = $clog2(CLKS_PER_LINE),
  localparam int LINE_W = $clog2(LINES_LONG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  syncCtl_t          ctl,
  output logic [LINE_W-1:0] lineNum,
  output logic [HPOS_W-1:0] linePos,
  output logic              syncN,
  output logic              hDriveN,
  output logic              fieldSecond,
  output logic              frameEnd
);
  localparam int SUB_W    = HPOS_W - 1;
  localparam int HALF_W   = LINE_W + 1;
  localparam int BROAD_LO = EQ_PULSES;
  localparam int BROAD_HI = EQ_PULSES + BROAD_PULSES;
  localparam int VI_END   = 2 * EQ_PULSES + BROAD_PULSES;
  localparam logic [LINE_W-1:0] VS_LINE = LINE_W'(EQ_PULSES / 2);
  localparam logic [HPOS_W-1:0] VS_HPOS = (EQ_PULSES % 2) != 0 ?
                                          HPOS_W'(CLKS_PER_LINE / 2) : '0;

  logic [HPOS_W-1:0] hPos, hNext;
  logic [LINE_W-1:0] lineCnt, lNext;
  logic [LINE_W-1:0] lastLine;
  logic [HALF_W-1:0] frameHalves, halfIdx, fieldHalf;
  logic [SUB_W-1:0]  sub;
  logic              secondNext, inEq, inBroad, syncNext, hDrvNext;

  assign lastLine = ctl.modeLong ? LINE_W'(LINES_LONG - 1) : LINE_W'(LINES_SHORT - 1);
  assign frameHalves = ctl.modeLong ? HALF_W'(LINES_LONG) : HALF_W'(LINES_SHORT);
  assign frameEnd = (hPos == HPOS_W'(CLKS_PER_LINE - 1)) && (lineCnt == lastLine);

  // next raster position
  always_comb begin
    hNext = hPos;
    lNext = lineCnt;
    if (ctl.jumpEq) begin
      hNext = '0;
      lNext = '0;
    end else if (ctl.jumpVs) begin
      hNext = VS_HPOS;
      lNext = VS_LINE;
    end else if (ctl.step) begin
      if (hPos == HPOS_W'(CLKS_PER_LINE - 1)) begin
        hNext = '0;
        lNext = (lineCnt == lastLine) ? '0 : lineCnt + 1'b1;
      end else begin
        hNext = hPos + 1'b1;
      end
    end
  end

  // decode of the next position, so outputs line up with the counters
  always_comb begin
    halfIdx    = {lNext, hNext[HPOS_W-1]};
    secondNext = halfIdx >= frameHalves;
    fieldHalf  = secondNext ? halfIdx - frameHalves : halfIdx;
    sub        = hNext[SUB_W-1:0];
    inBroad    = (fieldHalf >= HALF_W'(BROAD_LO)) && (fieldHalf < HALF_W'(BROAD_HI));
    inEq       = (fieldHalf < HALF_W'(VI_END)) && !inBroad;
    if (inBroad)   syncNext = !(sub < SUB_W'(BROAD_CLKS));
    else if (inEq) syncNext = !(sub < SUB_W'(EQ_CLKS));
    else           syncNext = !(hNext < HPOS_W'(HSYNC_CLKS));
    hDrvNext = !(hNext < HPOS_W'(HDRIVE_CLKS));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPos        <= '0;
      lineCnt     <= '0;
      syncN       <= 1'b0;
      hDriveN     <= 1'b0;
      fieldSecond <= 1'b0;
    end else begin
      hPos        <= hNext;
      lineCnt     <= lNext;
      syncN       <= syncNext;
      hDriveN     <= hDrvNext;
      fieldSecond <= secondNext;
    end
  end

  assign lineNum = lineCnt;
  assign linePos = hPos;

  p_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !ctl.jumpEq && !ctl.jumpVs) |=> (hPos == HPOS_W'($past(hPos) + 1'b1)));
  p_eq_target_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.jumpEq |=> (hPos == '0 && lineCnt == '0));
  p_vs_target_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.jumpVs |=> (hPos == VS_HPOS && lineCnt == VS_LINE));
  p_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.step |=> ($stable(hPos) && $stable(lineCnt) && $stable(syncN) && $stable(fieldSecond)));
  p_line_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    lineCnt <= lastLine);
  always_comb begin
    if (rstN) p_hdrive_r8: assert (hDriveN == (hPos >= HPOS_W'(HDRIVE_CLKS)));
  end
endmodule

// File: rtl/sync_gen.sv
module sync_gen
  import sync_gen_pkg::*;
#(
  parameter int CLKS_PER_LINE = 32,
  parameter int LINES_SHORT   = 525,
  parameter int LINES_LONG    = 625,
  parameter int EQ_PULSES     = 6,
  parameter int BROAD_PULSES  = 6,
  parameter int HSYNC_CLKS    = 2,
  parameter int EQ_CLKS       = 1,
  parameter int BROAD_CLKS    = 13,
  parameter int HDRIVE_CLKS   = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          clkEn,
  input  logic                          modeLong,
  input  logic                          eqResetN,
  input  logic                          vsResetN,
  output logic                          syncN,
  output logic                          hDriveN,
  output logic [$clog2(LINES_LONG)-1:0] lineNum,
  output logic [$clog2(CLKS_PER_LINE)-1:0] linePos,
  output logic                          fieldSecond
);
  syncCtl_t ctl;
  logic     frameEnd;

  sync_gen_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .modeLong(modeLong),
    .eqResetN(eqResetN), .vsResetN(vsResetN), .frameEnd(frameEnd), .ctl(ctl)
  );

  sync_gen_datapath #(
    .CLKS_PER_LINE(CLKS_PER_LINE), .LINES_SHORT(LINES_SHORT), .LINES_LONG(LINES_LONG),
    .EQ_PULSES(EQ_PULSES), .BROAD_PULSES(BROAD_PULSES), .HSYNC_CLKS(HSYNC_CLKS),
    .EQ_CLKS(EQ_CLKS), .BROAD_CLKS(BROAD_CLKS), .HDRIVE_CLKS(HDRIVE_CLKS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .lineNum(lineNum), .linePos(linePos),
    .syncN(syncN), .hDriveN(hDriveN), .fieldSecond(fieldSecond), .frameEnd(frameEnd)
  );
endmodule

// File: tb/sync_gen_tb.sv
`timescale 1ns/1ps
module sync_gen_tb;
  logic clk = 1'b0;
  logic rstN, clkEn, modeLong, eqResetN, vsResetN;
  logic syncN, hDriveN, fieldSecond;
  logic [9:0] lineNum;
  logic [4:0] linePos;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bench-side raster model
  int  mLine = 0, mPos = 0;
  bit  mLong = 0;

  always #2.5 clk = ~clk;

  sync_gen u_dut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .modeLong(modeLong),
    .eqResetN(eqResetN), .vsResetN(vsResetN), .syncN(syncN), .hDriveN(hDriveN),
    .lineNum(lineNum), .linePos(linePos), .fieldSecond(fieldSecond)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s line=%0d pos=%0d actual=%0d expected=%0d", req, mLine, mPos, act, exp);
    end
  endtask

  function automatic int fieldHalf(int line, int pos, bit lng);
    int lines = lng ? 625 : 525;
    int h = 2 * line + (pos >= 16 ? 1 : 0);
    return (h >= lines) ? h - lines : h;
  endfunction

  function automatic bit expSecond(int line, int pos, bit lng);
    return (2 * line + (pos >= 16 ? 1 : 0)) >= (lng ? 625 : 525);
  endfunction

  function automatic bit expSync(int line, int pos, bit lng);
    int f = fieldHalf(line, pos, lng);
    int sub = pos % 16;
    if (f >= 6 && f < 12) return sub >= 13;   // R6
    if (f < 18)           return sub != 0;    // R5
    return pos >= 2;                          // R4
  endfunction

  function automatic string syncReq(int line, int pos, bit lng);
    int f = fieldHalf(line, pos, lng);
    if (f >= 6 && f < 12) return "R6";
    if (f < 18) return "R5";
    return "R4";
  endfunction

  // model of one clock edge, per the requirements
  task automatic modelEdge(bit pend);
    if (!clkEn) return;
    if (!eqResetN) begin mLine = 0; mPos = 0; end
    else if (!vsResetN) begin mLine = 3; mPos = 0; end
    else if (mPos == 31) begin
      mPos = 0;
      if (mLine == (mLong ? 624 : 524)) begin mLine = 0; mLong = pend; end
      else mLine++;
    end else mPos++;
  endtask

  task automatic tick();
    @(posedge clk);
    modelEdge(modeLong);
    #1;
  endtask

  task automatic compareAll();
    check("R1", linePos, mPos);
    check("R2", lineNum, mLine);
    check(syncReq(mLine, mPos, mLong), syncN, expSync(mLine, mPos, mLong));
    check("R8", hDriveN, mPos >= 2);
    check("R7", fieldSecond, expSecond(mLine, mPos, mLong));
  endtask

  task automatic runCycles(int n);
    for (int i = 0; i < n; i++) begin
      tick();
      compareAll();
    end
  endtask

  task automatic testReset();
    rstN = 0; clkEn = 0; modeLong = 0; eqResetN = 1; vsResetN = 1;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    mLine = 0; mPos = 0; mLong = 0;
    check("R13", lineNum, 0);
    check("R13", linePos, 0);
    check("R13", syncN, 0);
    check("R13", hDriveN, 0);
    check("R13", fieldSecond, 0);
    clkEn = 1;
  endtask

  task automatic testFullShortFrame();
    bit sawSecond = 0;
    for (int i = 0; i < 525 * 32; i++) begin
      tick();
      compareAll();
      if (mLine == 262 && mPos == 16) begin
        check("R7", fieldSecond, 1);
        check("R5", syncN, 0);
        sawSecond = 1;
      end
      if (mLine == 3 && mPos == 13) check("R6", syncN, 1);
      if (mLine == 3 && mPos == 12) check("R6", syncN, 0);
      if (mLine == 271 && mPos == 20) check("R4", syncN, 1);
    end
    check("R7", sawSecond, 1);
    check("R2", lineNum, 0);   // 16800 steps wrap back to the start
    check("R2", linePos, 0);
  endtask

  task automatic testHold();
    int l = lineNum, p = linePos, s = syncN;
    clkEn = 0; eqResetN = 0;   // request must be ignored while disabled
    for (int i = 0; i < 10; i++) begin
      tick();
      check("R12", lineNum, l);
      check("R12", linePos, p);
      check("R12", syncN, s);
    end
    eqResetN = 1; clkEn = 1;
  endtask

  task automatic testVsJump();
    runCycles(100);
    vsResetN = 0;
    tick();
    vsResetN = 1;
    check("R10", lineNum, 3);
    check("R10", linePos, 0);
    check("R10", syncN, 0);
    runCycles(40);
  endtask

  task automatic testEqJump();
    eqResetN = 0;
    tick();
    eqResetN = 1;
    check("R9", lineNum, 0);
    check("R9", linePos, 0);
    runCycles(40);
  endtask

  task automatic testBothJump();
    runCycles(300);
    eqResetN = 0; vsResetN = 0;
    tick();
    eqResetN = 1; vsResetN = 1;
    check("R11", lineNum, 0);
    check("R11", linePos, 0);
    runCycles(10);
  endtask

  task automatic testModeChange();
    int maxLine = 0;
    runCycles(5000);
    modeLong = 1;
    // rest of this frame must still be 525 lines
    while (!(mLine == 0 && mPos == 0)) begin
      tick();
      compareAll();
      if (lineNum > maxLine) maxLine = lineNum;
    end
    check("R3", maxLine, 524);
    maxLine = 0;
    for (int i = 0; i < 625 * 32; i++) begin
      tick();
      compareAll();
      if (lineNum > maxLine) maxLine = lineNum;
      if (mLine == 312 && mPos == 16) check("R7", fieldSecond, 1);
      if (mLine == 312 && mPos == 15) check("R7", fieldSecond, 0);
    end
    check("R2", maxLine, 624);
    check("R2", lineNum, 0);
  endtask

  initial begin
    testReset();
    testFullShortFrame();
    testHold();
    testVsJump();
    testEqJump();
    testBothJump();
    testModeChange();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule